// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block decides when a byte-wide parallel NOR flash has finished an embedded program or erase. After a start pulse it issues single reads to a bus master through a request/acknowledge handshake. It examines one status bit of each returned byte and finishes when that bit shows the operation is complete.

Two methods are supported. In toggle mode, the device's bit 6 keeps inverting while the operation runs, so the block takes one reference read and then compares bit 6 of each later read with the read before it. In data mode, the block compares bit 7 of each read with bit 7 of the expected data. A wait, given in clock cycles and loaded with the start pulse, is inserted before every compared read. Long erases use a wait worth several milliseconds, and byte programs use none.

Both modes share one iteration counter. When the counter reaches a hard limit, the block gives up and reports a timeout. A lower threshold raises a sticky "slow" warning, but the poll keeps running to its normal end.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `rd_req_o`, `busy_o`, `done_o`, `timeout_o` and `slow_o` are all 0.
- R2: Toggle mode (`mode_i` = 0): the first read is a reference and is not counted. Each later read is one iteration, and its bit 6 is compared with bit 6 of the read just before it. The first iteration where the two values are equal completes the operation. Bit 7 and the other bits are ignored.
- R3: Data mode (`mode_i` = 1): only bit 7 of `expect_i` is kept, captured at start. Every read is one iteration, and the operation completes on the first read whose bit 7 equals it. Bit 6 and the other bits are ignored.
- R4: Between the acknowledge of a read and the next request of the same operation, `rd_req_o` is low for exactly `delay_i`+1 cycles, where `delay_i` is the value captured at start.
- R5: `rd_req_o` stays high until a cycle in which `rd_ack_i` is high, and it is low in the next cycle. Only one read is outstanding at a time.
- R6: If `POLL_LIMIT` iterations pass without completion, the block returns to idle, sets `timeout_o`, and does not pulse `done_o`. A match on iteration `POLL_LIMIT` itself still counts as completion.
- R7: `slow_o` is set once the iteration count exceeds `WARN_LIMIT`, and the operation continues to its normal end. A finish at exactly `WARN_LIMIT` iterations leaves `slow_o` at 0.
- R8: `timeout_o` and `slow_o` hold their values while idle and are cleared in the cycle after a start is accepted.
- R9: A start pulse while `busy_o` is high is ignored, including its mode, expected data and delay.
- R10: On completion, `done_o` is high for exactly one cycle, the cycle after the final acknowledge, and `busy_o` is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mode_i | input | 1 | 0 = toggle-bit polling, 1 = data polling |
| expect_i | input | DATA_W | Expected data; only bit 7 is used in data mode |
| delay_i | input | DLY_W | Wait in cycles before each compared read |
| rd_req_o | output | 1 | Read request to the bus master |
| rd_ack_i | input | 1 | Read acknowledge, with valid `rd_data_i` |
| rd_data_i | input | DATA_W | Byte returned by the read |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Sticky: iteration limit reached |
| slow_o | output | 1 | Sticky: warning threshold exceeded |

## Verification
The final poll read can both complete the operation and be the iteration that reaches the hard limit. The block must then report completion and not a timeout. This case is provoked in data mode by returning the matching bit 7 on exactly the `POLL_LIMIT`-th read. The outcome is judged by `done_o` pulsing with `timeout_o` low. The same acknowledge can also cross the warning threshold, so an operation that finishes one iteration past `WARN_LIMIT` must show both `done_o` and `slow_o`, while one that finishes exactly at the threshold must not.

// File: rtl/flash_poll_pkg.sv
// Shared types for the flash completion poller.
// Assumes: a single clock domain; the mode encoding is fixed by the top ports.
package flash_poll_pkg;

    // Polling method, encoded as on mode_i
    typedef enum logic {
        MODE_TOGGLE = 1'b0,
        MODE_DATA   = 1'b1
    } poll_mode_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REF  = 2'd1,
        ST_WAIT = 2'd2,
        ST_POLL = 2'd3
    } poll_state_e;

endpackage

// File: rtl/poll_wait_timer.sv
// Inter-read wait timer.
// Loads a cycle count and counts down while run_i is high.
// expired_o is high when the count is zero.
// Assumes: load_i and run_i are never high in the same cycle.
module poll_wait_timer #(
    parameter int unsigned DLY_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             expired_o
);
    logic [DLY_W-1:0] cnt_q;

    // Load or count down the remaining wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/poll_iter_counter.sv
// Iteration counter shared by both polling modes.
// Reports whether the next step is the last allowed one, and whether
// the next step pushes the count past the warning threshold.
// Assumes: step_i is never high once the limit has been reached.
module poll_iter_counter #(
    parameter int unsigned LIMIT = 32'h0FFF_FFFF,
    parameter int unsigned WARN  = 32'h0010_0000,
    parameter int unsigned CNT_W = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o,
    output logic over_warn_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] count_q;

    // Count compared reads of the current operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (step_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    // The step about to happen is iteration count_q+1
    assign last_o      = (count_q == LAST_IDX);
    assign over_warn_o = (32'(count_q) >= WARN);
endmodule

// File: rtl/poll_status_compare.sv
// Status-bit comparator.
// Holds the reference bit: the expected bit in data mode, or the previous
// read's toggle bit in toggle mode. It flags a match for the current read.
// Assumes: bit positions lie inside DATA_W.
module poll_status_compare
    import flash_poll_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned TOGGLE_BIT = 6,
    parameter int unsigned DATA_BIT   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  poll_mode_e        mode_i,
    input  logic              load_i,
    input  logic              load_bit_i,
    input  logic              update_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              match_o
);
    logic ref_q;
    logic watched_bit;

    // Pick the status bit that the active mode watches
    always_comb begin
        if (mode_i == MODE_DATA) watched_bit = rd_data_i[DATA_BIT];
        else                     watched_bit = rd_data_i[TOGGLE_BIT];
    end

    // Keep the reference bit for the next comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
        end else if (load_i) begin
            ref_q <= load_bit_i;
        end else if (update_i) begin
            ref_q <= rd_data_i[TOGGLE_BIT];
        end
    end

    assign match_o = (watched_bit == ref_q);
endmodule

// File: rtl/flash_done_poller.sv
// Flash operation completion poller (top).
// A start pulse begins a poll in toggle or data mode. The block issues one
// read at a time, waits a loaded number of cycles before each compared
// read, and finishes on a status match or on the iteration limit.
// Assumes: the bus master returns rd_ack_i for every request, holding
// rd_data_i valid in the acknowledge cycle.
module flash_done_poller
    import flash_poll_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned DLY_W      = 24,
    parameter int unsigned POLL_LIMIT = 32'h0FFF_FFFF,
    parameter int unsigned WARN_LIMIT = 32'h0010_0000,
    parameter int unsigned TOGGLE_BIT = 6,
    parameter int unsigned DATA_BIT   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] expect_i,
    input  logic [DLY_W-1:0]  delay_i,
    output logic              rd_req_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic              slow_o
);
    localparam int unsigned CNT_W = $clog2(POLL_LIMIT + 1);

    poll_state_e      state_q, state_d;
    poll_mode_e       mode_q;
    logic [DLY_W-1:0] dly_q;
    logic             done_q, tmo_q, slow_q;

    logic accept, ref_fire, poll_fire, finish_ok, finish_to;
    logic tmr_load, tmr_expired;
    logic [DLY_W-1:0] tmr_val;
    logic it_last, it_over;
    logic cmp_update, cmp_match;

    // Decode the events of this cycle
    always_comb begin
        accept     = start_i && (state_q == ST_IDLE);
        ref_fire   = (state_q == ST_REF)  && rd_ack_i;
        poll_fire  = (state_q == ST_POLL) && rd_ack_i;
        finish_ok  = poll_fire && cmp_match;
        finish_to  = poll_fire && !cmp_match && it_last;
        tmr_load   = accept || ref_fire || (poll_fire && !cmp_match && !it_last);
        tmr_val    = accept ? delay_i : dly_q;
        cmp_update = (ref_fire || poll_fire) && (mode_q == MODE_TOGGLE);
    end

    // Next-state sequencing
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (accept)
                         state_d = (poll_mode_e'(mode_i) == MODE_TOGGLE) ? ST_REF : ST_WAIT;
            ST_REF:  if (rd_ack_i) state_d = ST_WAIT;
            ST_WAIT: if (tmr_expired) state_d = ST_POLL;
            ST_POLL: if (rd_ack_i)
                         state_d = (finish_ok || finish_to) ? ST_IDLE : ST_WAIT;
            default: state_d = ST_IDLE;
        endcase
    end

    // State, latched operation settings and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_TOGGLE;
            dly_q   <= '0;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
            slow_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish_ok;
            if (accept) begin
                mode_q <= poll_mode_e'(mode_i);
                dly_q  <= delay_i;
                tmo_q  <= 1'b0;
                slow_q <= 1'b0;
            end else begin
                if (finish_to)           tmo_q  <= 1'b1;
                if (poll_fire && it_over) slow_q <= 1'b1;
            end
        end
    end

    poll_wait_timer #(
        .DLY_W(DLY_W)
    ) wait_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .run_i      (state_q == ST_WAIT),
        .expired_o  (tmr_expired)
    );

    poll_iter_counter #(
        .LIMIT (POLL_LIMIT),
        .WARN  (WARN_LIMIT),
        .CNT_W (CNT_W)
    ) iter_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (accept),
        .step_i      (poll_fire),
        .last_o      (it_last),
        .over_warn_o (it_over)
    );

    poll_status_compare #(
        .DATA_W     (DATA_W),
        .TOGGLE_BIT (TOGGLE_BIT),
        .DATA_BIT   (DATA_BIT)
    ) cmp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_q),
        .load_i     (accept),
        .load_bit_i (expect_i[DATA_BIT]),
        .update_i   (cmp_update),
        .rd_data_i  (rd_data_i),
        .match_o    (cmp_match)
    );

    assign rd_req_o  = (state_q == ST_REF) || (state_q == ST_POLL);
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign timeout_o = tmo_q;
    assign slow_o    = slow_q;
endmodule

// File: rtl/flash_done_poller_chk.sv
// Protocol and timing checker for flash_done_poller, attached by bind.
// It measures the request gap after each acknowledge with its own counter.
module flash_done_poller_chk #(
    parameter int unsigned DLY_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [DLY_W-1:0] delay_i,
    input logic             rd_req_o,
    input logic             rd_ack_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             timeout_o,
    input logic             slow_o
);
    logic [DLY_W-1:0] dly_l;
    logic [DLY_W:0]   gap;
    logic             armed;

    // Track the low cycles of rd_req_o since the last acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_l <= '0;
            gap   <= '0;
            armed <= 1'b0;
        end else begin
            if (start_i && !busy_o) dly_l <= delay_i;
            if (rd_req_o && rd_ack_i) begin
                armed <= 1'b1;
                gap   <= '0;
            end else if (armed && rd_req_o) begin
                armed <= 1'b0;
            end else if (armed) begin
                gap <= gap + 1'b1;
            end
            if (!busy_o) armed <= 1'b0;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!rd_req_o && !busy_o && !done_o && !timeout_o && !slow_o));

    p_gap_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rd_req_o && busy_o) |-> (gap == ({1'b0, dly_l} + 1'b1)));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);

    p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i) |=> !rd_req_o);

    p_timeout_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (!done_o && !busy_o));

    p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (!timeout_o && !slow_o && busy_o));

    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(timeout_o) && $stable(slow_o)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

bind flash_done_poller flash_done_poller_chk #(
    .DLY_W(DLY_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .delay_i   (delay_i),
    .rd_req_o  (rd_req_o),
    .rd_ack_i  (rd_ack_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .timeout_o (timeout_o),
    .slow_o    (slow_o)
);

// File: tb/flash_done_poller_tb_top.sv
// Scoreboard bench: the driver queues the expected outcome of each poll,
// a responder plays the flash, and a monitor compares at the end of each poll.
module flash_done_poller_tb_top;
    localparam int LIM = 20;
    localparam int WRN = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mode = 1'b0;
    logic [7:0] exp_b = 8'h00;
    logic [7:0] dly = 8'h00;
    logic       ack = 1'b0;
    logic [7:0] rdat = 8'h00;
    logic       req, busy, done, tmo, slow;

    always #5 clk = ~clk;

    flash_done_poller #(
        .DATA_W(8), .DLY_W(8), .POLL_LIMIT(LIM), .WARN_LIMIT(WRN),
        .TOGGLE_BIT(6), .DATA_BIT(7)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .expect_i(exp_b), .delay_i(dly), .rd_req_o(req), .rd_ack_i(ack),
        .rd_data_i(rdat), .busy_o(busy), .done_o(done),
        .timeout_o(tmo), .slow_o(slow)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit to;
        bit sl;
        int reads;
    } exp_t;
    exp_t q[$];

    bit   cur_mode = 1'b0;
    int   cur_n = 0, cur_lat = 0, cur_dly = 0, rd_idx = 0;
    logic cur_e7 = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Flash model: bit 6 toggles n times, or bit 7 stays inverted for n reads
    function automatic logic [7:0] gen(input int i);
        logic [7:0] b;
        b = 8'(i * 53 + 17);
        if (!cur_mode) begin
            b[6] = (i <= cur_n) ? i[0] : cur_n[0];
        end else begin
            b[7] = (i < cur_n) ? ~cur_e7 : cur_e7;
            b[6] = i[0];
        end
        return b;
    endfunction

    // Responder: answers each request after cur_lat cycles
    initial begin
        forever begin
            @(posedge clk); #1;
            if (req && !ack) begin
                repeat (cur_lat) begin @(posedge clk); #1; end
                rdat = gen(rd_idx);
                rd_idx++;
                ack = 1'b1;
                @(posedge clk); #1;
                ack = 1'b0;
            end
        end
    end

    // Monitor: counts reads, checks gaps, compares outcomes at poll end
    initial begin
        int   reads = 0;
        int   gap = 0;
        int   dones = 0;
        bit   armed = 0;
        bit   pb = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (done) begin
                    dones++;
                    chk(!busy, "R10 busy low during done", int'(busy), 0);
                end
                if (req && ack) begin
                    reads++;
                    armed = 1;
                    gap = 0;
                end else if (armed && req) begin
                    chk(gap == cur_dly + 1, "R4 request gap", gap, cur_dly + 1);
                    armed = 0;
                end else if (armed && busy) begin
                    gap++;
                end
                if (pb && !busy) begin
                    if (q.size() == 0) begin
                        chk(0, "R9 unexpected completion", 1, 0);
                    end else begin
                        e = q.pop_front();
                        chk(tmo == e.to, "R6 timeout flag", int'(tmo), int'(e.to));
                        chk(slow == e.sl, "R7 slow flag", int'(slow), int'(e.sl));
                        chk(reads == e.reads, "R2 R3 read count", reads, e.reads);
                        chk(dones == (e.to ? 0 : 1), "R10 done pulses", dones, e.to ? 0 : 1);
                    end
                    reads = 0;
                    dones = 0;
                    armed = 0;
                end
                pb = busy;
            end
        end
    end

    // Driver: queue the expected outcome, start the poll, wait for its end
    task automatic run_op(input bit m, input logic [7:0] e, input int d,
                          input int n, input int lat, input bit poke);
        exp_t x;
        int   cmp;
        cmp   = n + 1;
        x.to  = (cmp > LIM);
        if (x.to) cmp = LIM;
        x.sl    = (cmp > WRN);
        x.reads = cmp + (m ? 0 : 1);
        q.push_back(x);
        cur_mode = m; cur_n = n; cur_lat = lat; cur_e7 = e[7]; cur_dly = d; rd_idx = 0;
        @(negedge clk);
        mode = m; exp_b = e; dly = 8'(d); start = 1'b1;
        @(negedge clk);
        start = 1'b0; mode = 1'b0; exp_b = 8'h00; dly = 8'h00;
        chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
        chk(tmo == 1'b0, "R8 timeout cleared", int'(tmo), 0);
        chk(slow == 1'b0, "R8 slow cleared", int'(slow), 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            mode = ~m; exp_b = ~e; dly = 8'd7; start = 1'b1;   // R9: must be ignored
            @(negedge clk);
            start = 1'b0; mode = 1'b0; exp_b = 8'h00; dly = 8'h00;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(tmo == x.to, "R8 timeout sticky", int'(tmo), int'(x.to));
        chk(slow == x.sl, "R8 slow sticky", int'(slow), int'(x.sl));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(req == 0,  "R1 rd_req_o in reset", int'(req), 0);
        chk(busy == 0, "R1 busy_o in reset", int'(busy), 0);
        chk(done == 0, "R1 done_o in reset", int'(done), 0);
        chk(tmo == 0,  "R1 timeout_o in reset", int'(tmo), 0);
        chk(slow == 0, "R1 slow_o in reset", int'(slow), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(1'b0, 8'h00, 0, 0, 0, 1'b0);   // R2: stable at once
        run_op(1'b0, 8'h5A, 3, 5, 1, 1'b0);   // R2 R4: toggling, wait 3
        run_op(1'b1, 8'h80, 0, 0, 0, 1'b0);   // R3: first read matches
        run_op(1'b1, 8'h00, 2, 4, 2, 1'b0);   // R3: expected bit 7 = 0
        run_op(1'b1, 8'hFF, 1, 7, 0, 1'b0);   // R7: exactly at threshold
        run_op(1'b1, 8'h80, 0, 8, 1, 1'b0);   // R7: one past threshold
        run_op(1'b1, 8'h7F, 0, LIM - 1, 0, 1'b0); // R6: match on last iteration
        run_op(1'b0, 8'h00, 0, 30, 0, 1'b0);  // R6: toggle timeout
        run_op(1'b1, 8'h80, 1, 25, 0, 1'b0);  // R6 R8: data timeout after timeout
        run_op(1'b0, 8'h00, 2, 6, 1, 1'b1);   // R9: start while busy
        run_op(1'b1, 8'h80, 5, 3, 0, 1'b1);   // R9 R4: start while busy, wait 5

        chk(q.size() == 0, "R10 all polls completed", q.size(), 0);
        summary();
        $finish;
    end
endmodule